// File: doc/BRIEF.md
# Serial Frame Start Trigger Detector

This block decides the moment a synchronous serial receiver or transmitter opens a frame. It samples a frame-sync pin on every bit-clock enable cycle. A four-bit mode field picks what counts as the start condition: the sync pin's level or edges, a start strobe from the opposite direction, a match flag from a received-data comparator, or free-running operation. Once the chosen condition is seen, the block counts a programmable number of bit clocks and then raises a one-cycle start pulse.

A second, independent path produces a bit-clock gate that follows the sync pin's level. A sticky flag records that a sync-pin event was seen. Compare mode exists only when the `RX_SIDE` parameter is set. A stop-select input decides whether a second comparator match re-arms compare mode or whether reception simply keeps running. Clock generation and data shifting belong to the surrounding receiver or transmitter.

Top module: `frame_start_trigger`

## Requirements
- R1: The sync pin is sampled on cycles with `bit_en` high, and edge modes compare the current pin with the previous sample. The `start_sel` values for the sync pin are: 2 when the pin is low, 3 when it is high, 4 on a falling edge, 5 on a rising edge, 6 or 7 on any change.
- R2: With `start_delay` = D, the start pulse is high for the clock cycle that follows the D-th `bit_en` cycle after the trigger's `bit_en` cycle. With D = 0 it is high in the cycle that follows the trigger itself.
- R3: With `start_sel` = 0 (continuous), the block triggers on the first `bit_en` cycle after it is enabled, and again on every `bit_en` cycle with `frame_end` high.
- R4: With `start_sel` = 1, the block triggers on a `bit_en` cycle with `peer_start` high.
- R5: With `start_sel` = 8 and `RX_SIDE` set, a `cmp0_hit` triggers once and then locks compare mode. While `stop_on_cmp1` is 1, a `cmp1_hit` on a `bit_en` cycle re-arms it. While `stop_on_cmp1` is 0, further `cmp0_hit` events are ignored until the block is disabled.
- R6: `start_sel` values 9 to 15 never produce a start pulse, whatever the other inputs do.
- R7: A trigger that arrives while a delay countdown is pending, including on the cycle the countdown ends, is ignored.
- R8: `clk_gate` depends only on `gate_sel` and `sync_in`: 0 gives always 1, 1 gives the inverse of `sync_in`, 2 gives `sync_in`, 3 gives 0.
- R9: `sync_seen` is set one cycle after a `bit_en` cycle on which a sync-pin mode (2 to 7) finds its condition true. It stays set while the block is enabled. Other modes never set it.
- R10: When `enable` is low, the block clears the countdown, the previous sync sample, the compare lock and `sync_seen` on the next clock, and the start pulse stays low.
- R11: The sync sampling and the delay countdown advance only on `bit_en` cycles.
- R12: After reset, `start_pulse` and `sync_seen` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low clears the trigger state |
| bit_en | input | 1 | One-cycle bit-clock enable |
| sync_in | input | 1 | Frame-sync pin, synchronous to clk |
| peer_start | input | 1 | Start strobe from the opposite direction |
| cmp0_hit | input | 1 | First comparator match |
| cmp1_hit | input | 1 | Second comparator match |
| frame_end | input | 1 | Frame boundary marker for continuous mode |
| start_sel | input | 4 | Start condition select |
| start_delay | input | DLY_W | Bit clocks between trigger and start |
| gate_sel | input | 2 | Clock gating select |
| stop_on_cmp1 | input | 1 | Re-arm compare mode on the second match |
| start_pulse | output | 1 | One-cycle frame start |
| clk_gate | output | 1 | Bit-clock allow |
| sync_seen | output | 1 | Sticky sync-event flag |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that `start_sel`, `start_delay` and `stop_on_cmp1` only change while `enable` is low, so a pending countdown always belongs to the mode that started it. The stimulus keeps to this: it changes inputs only at falling edges, and it rewrites the configuration only after a cycle with `enable` low. The sweeps cover every sync-pin mode against several delays, every reserved code, and every gate code with both pin levels.

// File: rtl/frame_start_trigger.sv
module frame_start_trigger #(
  parameter int DLY_W   = 8,
  parameter bit RX_SIDE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             bit_en,
  input  logic             sync_in,
  input  logic             peer_start,
  input  logic             cmp0_hit,
  input  logic             cmp1_hit,
  input  logic             frame_end,
  input  logic [3:0]       start_sel,
  input  logic [DLY_W-1:0] start_delay,
  input  logic [1:0]       gate_sel,
  input  logic             stop_on_cmp1,
  output logic             start_pulse,
  output logic             clk_gate,
  output logic             sync_seen
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] cnt;
  logic busy, prev_s, first, locked;
  logic cond, pin_mode, take;

  always_comb begin
    cond = 1'b0;
    pin_mode = 1'b0;
    case (start_sel)
      4'd0: cond = first | frame_end;
      4'd1: cond = peer_start;
      4'd2: begin cond = !sync_in;           pin_mode = 1'b1; end
      4'd3: begin cond = sync_in;            pin_mode = 1'b1; end
      4'd4: begin cond = prev_s & !sync_in;  pin_mode = 1'b1; end
      4'd5: begin cond = !prev_s & sync_in;  pin_mode = 1'b1; end
      4'd6, 4'd7: begin cond = prev_s ^ sync_in; pin_mode = 1'b1; end
      4'd8: cond = RX_SIDE & cmp0_hit & !locked;
      default: cond = 1'b0;
    endcase
  end

  assign take = enable & bit_en & !busy & cond;

  always_comb begin
    case (gate_sel)
      2'd0: clk_gate = 1'b1;
      2'd1: clk_gate = !sync_in;
      2'd2: clk_gate = sync_in;
      default: clk_gate = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; busy <= 1'b0; prev_s <= 1'b0; first <= 1'b1;
      locked <= 1'b0; start_pulse <= 1'b0; sync_seen <= 1'b0;
    end else if (!enable) begin
      cnt <= '0; busy <= 1'b0; prev_s <= 1'b0; first <= 1'b1;
      locked <= 1'b0; start_pulse <= 1'b0; sync_seen <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      if (bit_en) prev_s <= sync_in;
      if (bit_en && pin_mode && cond) sync_seen <= 1'b1;
      if (bit_en && stop_on_cmp1 && cmp1_hit) locked <= 1'b0;
      if (take) begin
        if (start_sel == 4'd0) first <= 1'b0;
        if (start_sel == 4'd8) locked <= 1'b1;
        if (start_delay == '0) start_pulse <= 1'b1;
        else begin
          busy <= 1'b1;
          cnt  <= start_delay;
        end
      end else if (busy && bit_en) begin
        cnt <= cnt - ONE;
        if (cnt == ONE) begin
          busy <= 1'b0;
          start_pulse <= 1'b1;
        end
      end
    end
  end

  // R2
  pulse_on_bit_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(bit_en));
  // R11
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && busy && !bit_en) |=> $stable(cnt));
  // R10
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!start_pulse && !busy && !sync_seen));
  // R9
  seen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sync_seen) |=> sync_seen);
  // R6
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_sel > 4'd8 && !busy) |=> !start_pulse);
  // R7
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && busy && !(bit_en && cnt == ONE)) |=> busy);
  // R8
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_sel == 2'd3) |-> !clk_gate);
endmodule

// File: tb/frame_start_trigger_test.sv
module frame_start_trigger_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, bit_en = 1'b0, sync_in = 1'b0;
  logic peer_start = 1'b0, cmp0_hit = 1'b0, cmp1_hit = 1'b0, frame_end = 1'b0;
  logic [3:0] start_sel = '0;
  logic [7:0] start_delay = '0;
  logic [1:0] gate_sel = '0;
  logic stop_on_cmp1 = 1'b0;
  logic start_pulse, clk_gate, sync_seen;

  int checks = 0, failures = 0;
  bit done = 0;
  bit s_q[N], p_q[N], c0_q[N], c1_q[N], fe_q[N], be_q[N], got[N], seen_q[N];

  frame_start_trigger #(.DLY_W(8), .RX_SIDE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bit_en(bit_en), .sync_in(sync_in),
    .peer_start(peer_start), .cmp0_hit(cmp0_hit), .cmp1_hit(cmp1_hit),
    .frame_end(frame_end), .start_sel(start_sel), .start_delay(start_delay),
    .gate_sel(gate_sel), .stop_on_cmp1(stop_on_cmp1), .start_pulse(start_pulse),
    .clk_gate(clk_gate), .sync_seen(sync_seen));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_seq();
    for (int i = 0; i < N; i++) begin
      s_q[i] = 0; p_q[i] = 0; c0_q[i] = 0; c1_q[i] = 0; fe_q[i] = 0; be_q[i] = 1;
      got[i] = 0; seen_q[i] = 0;
    end
  endtask

  task automatic go_off();
    enable = 0; bit_en = 1; sync_in = 0; peer_start = 0;
    cmp0_hit = 0; cmp1_hit = 0; frame_end = 0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run(input int n);
    enable = 1;
    for (int i = 0; i < n; i++) begin
      sync_in = s_q[i]; peer_start = p_q[i]; cmp0_hit = c0_q[i];
      cmp1_hit = c1_q[i]; frame_end = fe_q[i]; bit_en = be_q[i];
      @(posedge clk); #1;
      got[i] = start_pulse; seen_q[i] = sync_seen;
      @(negedge clk);
    end
  endtask

  function automatic int first_hit(input int n);
    for (int i = 0; i < n; i++) if (got[i]) return i;
    return -1;
  endfunction

  function automatic int hits(input int n);
    int c = 0;
    for (int i = 0; i < n; i++) c += int'(got[i]);
    return c;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int trig, exp_at;
    int dl[4] = '{0, 1, 2, 5};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(start_pulse == 0, "R12 pulse", int'(start_pulse), 0);
    chk(sync_seen == 0, "R12 seen", int'(sync_seen), 0);

    // R1 / R2 sweep over sync modes and delays
    for (int m = 2; m <= 7; m++) begin
      for (int d = 0; d < 4; d++) begin
        go_off(); clear_seq();
        start_sel = 4'(m); start_delay = 8'(dl[d]);
        s_q[2] = 1; s_q[3] = 1; s_q[4] = 1;
        case (m)
          2: trig = 0;
          4: trig = 5;
          default: trig = 2;
        endcase
        exp_at = trig + dl[d];
        run(16);
        chk(first_hit(16) == exp_at, "R1 R2 mode/delay", first_hit(16), exp_at);
      end
    end

    // R7 triggers during countdown ignored; R9 flag set on sync event
    go_off(); clear_seq();
    start_sel = 4'd5; start_delay = 8'd4;
    for (int i = 0; i < N; i++) s_q[i] = bit'(i % 2);
    run(13);
    chk(hits(13) == 2, "R7 count", hits(13), 2);
    chk(got[5] && got[11], "R7 positions", int'(got[5]) + int'(got[11]), 2);
    chk(!seen_q[0] && seen_q[1], "R9 set", int'(seen_q[1]) - int'(seen_q[0]), 1);
    go_off();
    // R10 flag cleared by disable
    chk(sync_seen == 0, "R10 seen clear", int'(sync_seen), 0);

    // R3 continuous
    go_off(); clear_seq();
    start_sel = 4'd0; start_delay = 8'd2; fe_q[6] = 1;
    run(12);
    chk(hits(12) == 2 && got[2] && got[8], "R3 continuous", hits(12), 2);

    // R4 opposite-direction start, R9 not set by it
    go_off(); clear_seq();
    start_sel = 4'd1; start_delay = 8'd0; p_q[3] = 1;
    for (int i = 0; i < N; i++) s_q[i] = bit'(i % 2);
    run(8);
    chk(first_hit(8) == 3 && hits(8) == 1, "R4 peer", first_hit(8), 3);
    chk(seen_q[7] == 0, "R9 peer no flag", int'(seen_q[7]), 0);

    // R5 compare, no re-arm
    go_off(); clear_seq();
    start_sel = 4'd8; start_delay = 8'd0; stop_on_cmp1 = 0;
    c0_q[2] = 1; c0_q[5] = 1; c1_q[4] = 1;
    run(8);
    chk(hits(8) == 1 && got[2], "R5 locked", hits(8), 1);
    // R5 compare with re-arm
    go_off(); clear_seq();
    stop_on_cmp1 = 1;
    c0_q[2] = 1; c1_q[4] = 1; c0_q[6] = 1;
    run(9);
    chk(hits(9) == 2 && got[2] && got[6], "R5 rearm", hits(9), 2);
    stop_on_cmp1 = 0;

    // R6 reserved codes
    for (int m = 9; m <= 15; m++) begin
      go_off(); clear_seq();
      start_sel = 4'(m); start_delay = 8'd0;
      for (int i = 0; i < N; i++) begin
        s_q[i] = bit'(i % 2); p_q[i] = 1; c0_q[i] = 1; fe_q[i] = 1;
      end
      run(10);
      chk(hits(10) == 0, "R6 reserved", hits(10), 0);
    end

    // R10 disable mid-countdown clears counter and previous sample
    go_off(); clear_seq();
    start_sel = 4'd5; start_delay = 8'd5;
    for (int i = 0; i < N; i++) s_q[i] = 1;
    run(3);
    chk(hits(3) == 0, "R10 before", hits(3), 0);
    go_off();
    run(8);
    chk(first_hit(8) == 5 && hits(8) == 1, "R10 restart", first_hit(8), 5);

    // R11 countdown advances only on bit_en
    go_off(); clear_seq();
    start_sel = 4'd5; start_delay = 8'd2;
    for (int i = 0; i < N; i++) begin s_q[i] = 1; be_q[i] = bit'(i % 2 == 0); end
    run(8);
    chk(first_hit(8) == 4, "R11 bit_en pacing", first_hit(8), 4);

    // R8 gate sweep
    go_off();
    for (int g = 0; g < 4; g++) begin
      for (int s = 0; s < 2; s++) begin
        int e;
        gate_sel = 2'(g); sync_in = bit'(s); #1;
        e = (g == 0) ? 1 : (g == 1) ? 1 - s : (g == 2) ? s : 0;
        chk(int'(clk_gate) == e, "R8 gate", int'(clk_gate), e);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule